// File: doc/BRIEF.md
# Background Debug Command Engine

This block interprets debug commands that a host delivers one byte at a time over a byte-wide shift link. Each time the physical layer completes a byte exchange it raises `host_valid` for one cycle, carrying the byte received from the host on `host_rx`. The byte the host collects on its next exchange is presented on `host_tx`. When the engine is idle, the first byte received is taken as an opcode. Opcodes that read a register load the shift buffer with the selected value. Opcodes that write a register collect one or two follow-on bytes and commit them together. One opcode raises a halt request to the CPU.

The selectable state is a control byte, a read-only flag byte from the rest of the chip, an address word, a data word and a set of breakpoint words. The written registers are driven out as ports so that the breakpoint comparators and the CPU interface can use them. Unknown opcodes leave all state untouched, so the host can resynchronise by sending no-operation bytes.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset `host_tx` is 0x00, `halt_req` is low, and the control, address, data and breakpoint registers are all zero.
- R2: Opcode 0x01 (control byte) and opcode 0x02 (flag input) put the 8-bit value on `host_tx` in the cycle after the opcode. After one further transfer `host_tx` returns to 0x00 and the next byte is decoded as an opcode.
- R3: Opcodes 0x03 (address), 0x04 (data) and 0x05+i (breakpoint i, i = 0..NUM_BP-1) put the low byte on `host_tx` after the opcode and the high byte after the first follow-on transfer. After the second transfer `host_tx` returns to 0x00.
- R4: The write opcodes are the matching read opcodes with bit 4 set. Opcode 0x11 takes one byte for the control register. Opcodes 0x13, 0x14 and 0x15+i each take two bytes, low byte first. There is no write opcode for the flag byte.
- R5: A written register keeps its old value until the final data byte of its command has been received, and changes only in the cycle after that byte.
- R6: Opcode 0x1F raises `halt_req` in the cycle after it is received. `halt_req` stays high until `resume_pulse` is seen. If an 0x1F opcode and `resume_pulse` arrive in the same cycle, the opcode wins.
- R7: Any other opcode, including 0x00, 0x12, unused read or write codes and 0x80–0xFF, changes no register, leaves `host_tx` at 0x00, and the next byte is decoded as an opcode.
- R8: Bytes the host sends during the follow-on transfers of a read command change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | One-cycle strobe: a byte exchange with the host has completed |
| host_rx | input | 8 | Byte received from the host, valid with `host_valid` |
| host_tx | output | 8 | Byte offered to the host on the next exchange |
| flags_in | input | 8 | Read-only flag byte from the surrounding logic |
| resume_pulse | input | 1 | Clears the halt request |
| halt_req | output | 1 | Halt request to the CPU (the CPU stops at its next instruction boundary) |
| ctrl_byte | output | 8 | Control register |
| addr_word | output | 16 | Address register |
| data_word | output | 16 | Data register |
| bp_words | output | 16*NUM_BP | Breakpoint registers; breakpoint i occupies bits [16*i+15:16*i] |

## Verification
A wrong transfer count or a corrupted phase shows up at once. The next opcode is either swallowed as data or answered early, so the very next `host_tx` value differs from the expected byte, or 0x00 appears where a register byte belongs. A wrong target index or a premature commit shows on the register ports one cycle after the offending byte. Reading the register back shows it again two transfers later. A halt flag that is lost or stuck shows on `halt_req` within one cycle.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam logic [7:0] OP_HALT = 8'h1F;

    typedef enum logic {
        PH_OPCODE = 1'b0,
        PH_DATA   = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        tgt;
        logic              wr;
        logic              last;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] tx;
        logic              halt;
    } eng_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
    parameter int NUM_BP = 6
) (
    input  logic [7:0] opcode,
    output logic       rd_hit,
    output logic       wr_hit,
    output logic       halt_hit,
    output logic [3:0] tgt,
    output logic       two_byte
);
    localparam logic [3:0] LAST_LO = 4'(4 + NUM_BP);

    logic [3:0] lo;
    logic       in_range;

    always_comb begin
        lo       = opcode[3:0];
        in_range = (lo >= 4'd1) && (lo <= LAST_LO);
        tgt      = lo - 4'd1;
        two_byte = (tgt >= 4'd2);
        rd_hit   = (opcode[7:4] == 4'h0) && in_range;
        wr_hit   = (opcode[7:4] == 4'h1) && in_range && (lo != 4'd2);
        halt_hit = (opcode == dbg_cmd_pkg::OP_HALT);
    end
endmodule

// File: rtl/dbg_cmd_regs.sv
module dbg_cmd_regs #(
    parameter int NUM_BP = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_tgt,
    input  logic [15:0]          wr_word,
    input  logic [7:0]           flags_in,
    input  logic [3:0]           rd_tgt,
    output logic [15:0]          rd_word,
    output logic [7:0]           ctrl_o,
    output logic [15:0]          addr_o,
    output logic [15:0]          data_o,
    output logic [NUM_BP*16-1:0] bp_o
);
    localparam int NW = NUM_BP + 2;
    localparam int IW = $clog2(NW);

    logic [7:0]  ctrl_d, ctrl_q;
    logic [15:0] wd_d [NW];
    logic [15:0] wd_q [NW];
    logic [3:0]  wr_w, rd_w;

    always_comb begin
        wr_w   = wr_tgt - 4'd2;
        ctrl_d = ctrl_q;
        for (int i = 0; i < NW; i++) wd_d[i] = wd_q[i];
        if (wr_en) begin
            if (wr_tgt == 4'd0) ctrl_d = wr_word[7:0];
            else if (wr_tgt >= 4'd2 && int'(wr_w) < NW) wd_d[wr_w[IW-1:0]] = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < NW; i++) wd_q[i] <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            for (int i = 0; i < NW; i++) wd_q[i] <= wd_d[i];
        end
    end

    always_comb begin
        rd_w = rd_tgt - 4'd2;
        if (rd_tgt == 4'd0)                rd_word = {8'h00, ctrl_q};
        else if (rd_tgt == 4'd1)           rd_word = {8'h00, flags_in};
        else if (int'(rd_w) < NW)          rd_word = wd_q[rd_w[IW-1:0]];
        else                               rd_word = '0;
    end

    assign ctrl_o = ctrl_q;
    assign addr_o = wd_q[0];
    assign data_o = wd_q[1];

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        assign bp_o[g*16 +: 16] = wd_q[g+2];
    end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
    parameter int NUM_BP = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_valid,
    input  logic [7:0]           host_rx,
    output logic [7:0]           host_tx,
    input  logic [7:0]           flags_in,
    input  logic                 resume_pulse,
    output logic                 halt_req,
    output logic [7:0]           ctrl_byte,
    output logic [15:0]          addr_word,
    output logic [15:0]          data_word,
    output logic [NUM_BP*16-1:0] bp_words
);
    import dbg_cmd_pkg::*;

    eng_t        st_d, st_q;
    logic        rd_hit, wr_hit, halt_hit, two_byte;
    logic [3:0]  dec_tgt;
    logic [15:0] rd_word;
    logic        wr_en;
    logic [15:0] wr_word;

    dbg_cmd_decode #(.NUM_BP(NUM_BP)) u_dec (
        .opcode   (host_rx),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit),
        .halt_hit (halt_hit),
        .tgt      (dec_tgt),
        .two_byte (two_byte)
    );

    dbg_cmd_regs #(.NUM_BP(NUM_BP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_tgt   (st_q.tgt),
        .wr_word  (wr_word),
        .flags_in (flags_in),
        .rd_tgt   (dec_tgt),
        .rd_word  (rd_word),
        .ctrl_o   (ctrl_byte),
        .addr_o   (addr_word),
        .data_o   (data_word),
        .bp_o     (bp_words)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_word = (st_q.tgt < 4'd2) ? {8'h00, host_rx} : {host_rx, st_q.lo};
        if (resume_pulse) st_d.halt = 1'b0;
        if (host_valid) begin
            if (st_q.phase == PH_OPCODE) begin
                st_d.tgt  = dec_tgt;
                st_d.last = !two_byte;
                st_d.tx   = 8'h00;
                if (rd_hit) begin
                    st_d.phase = PH_DATA;
                    st_d.wr    = 1'b0;
                    st_d.tx    = rd_word[7:0];
                    st_d.hi    = rd_word[15:8];
                end else if (wr_hit) begin
                    st_d.phase = PH_DATA;
                    st_d.wr    = 1'b1;
                end else if (halt_hit) begin
                    st_d.halt  = 1'b1;
                end
            end else if (st_q.last) begin
                st_d.phase = PH_OPCODE;
                st_d.tx    = 8'h00;
                wr_en      = st_q.wr;
            end else begin
                st_d.last = 1'b1;
                st_d.lo   = host_rx;
                st_d.tx   = st_q.wr ? 8'h00 : st_q.hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_OPCODE, default: '0};
        else        st_q <= st_d;
    end

    assign host_tx  = st_q.tx;
    assign halt_req = st_q.halt;
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic [7:0]  host_rx,
    input logic        resume_pulse,
    input logic        halt_req,
    input logic [7:0]  ctrl_byte,
    input logic [15:0] addr_word,
    input logic [15:0] data_word
);
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !resume_pulse) |=> halt_req);

    assert_halt_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(host_valid && host_rx == 8'h1F));

    assert_halt_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_req) |-> $past(resume_pulse));

    assert_ctrl_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> $stable(ctrl_byte));

    assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> $stable(addr_word));

    assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> $stable(data_word));
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_valid   (host_valid),
    .host_rx      (host_rx),
    .resume_pulse (resume_pulse),
    .halt_req     (halt_req),
    .ctrl_byte    (ctrl_byte),
    .addr_word    (addr_word),
    .data_word    (data_word)
);

// File: tb/dbg_cmd_engine_test.sv
module dbg_cmd_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NBP = 6;
    localparam int NV = 32;
    localparam logic [7:0] FLAGS = 8'hA5;

    // {host byte, expected host_tx after it, expected halt_req after it, requirement number}
    localparam logic [20:0] VEC [NV] = '{
        {8'h01, 8'h00, 1'b0, 4'd2},   // R2 read control (zero)
        {8'h55, 8'h00, 1'b0, 4'd2},   // R2 one follow-on, back to idle
        {8'h11, 8'h00, 1'b0, 4'd4},   // R4 write control
        {8'h3C, 8'h00, 1'b0, 4'd4},
        {8'h01, 8'h3C, 1'b0, 4'd4},   // R4 read back
        {8'h00, 8'h00, 1'b0, 4'd2},
        {8'h02, FLAGS, 1'b0, 4'd2},   // R2 flag byte
        {8'h77, 8'h00, 1'b0, 4'd2},
        {8'h13, 8'h00, 1'b0, 4'd4},   // R4 write address low first
        {8'h34, 8'h00, 1'b0, 4'd5},
        {8'h12, 8'h00, 1'b0, 4'd5},
        {8'h03, 8'h34, 1'b0, 4'd3},   // R3 low then high
        {8'h99, 8'h12, 1'b0, 4'd8},   // R8 host byte ignored
        {8'hAB, 8'h00, 1'b0, 4'd8},
        {8'h03, 8'h34, 1'b0, 4'd8},   // R8 address unchanged
        {8'h00, 8'h12, 1'b0, 4'd3},
        {8'h00, 8'h00, 1'b0, 4'd3},
        {8'h1A, 8'h00, 1'b0, 4'd4},   // R4 write last breakpoint
        {8'hEF, 8'h00, 1'b0, 4'd4},
        {8'hBE, 8'h00, 1'b0, 4'd4},
        {8'h0A, 8'hEF, 1'b0, 4'd3},   // R3 read last breakpoint
        {8'h00, 8'hBE, 1'b0, 4'd3},
        {8'h00, 8'h00, 1'b0, 4'd3},
        {8'h12, 8'h00, 1'b0, 4'd7},   // R7 no flag write code
        {8'h04, 8'h00, 1'b0, 4'd7},   // R7 next byte is an opcode
        {8'h00, 8'h00, 1'b0, 4'd7},
        {8'h00, 8'h00, 1'b0, 4'd7},
        {8'h0B, 8'h00, 1'b0, 4'd7},   // R7 unused read code
        {8'h1F, 8'h00, 1'b1, 4'd6},   // R6 halt
        {8'h05, 8'h00, 1'b1, 4'd6},
        {8'h00, 8'h00, 1'b1, 4'd6},
        {8'h00, 8'h00, 1'b1, 4'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_valid = 1'b0;
    logic [7:0]        host_rx = 8'h00;
    logic [7:0]        host_tx;
    logic [7:0]        flags_in = FLAGS;
    logic              resume_pulse = 1'b0;
    logic              halt_req;
    logic [7:0]        ctrl_byte;
    logic [15:0]       addr_word, data_word;
    logic [NBP*16-1:0] bp_words;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cmd_engine #(.NUM_BP(NBP)) uut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_rx(host_rx),
        .host_tx(host_tx), .flags_in(flags_in), .resume_pulse(resume_pulse),
        .halt_req(halt_req), .ctrl_byte(ctrl_byte), .addr_word(addr_word),
        .data_word(data_word), .bp_words(bp_words)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one byte for one cycle; return at the negedge after the capturing edge
    task automatic xfer(logic [7:0] b, logic res = 1'b0);
        @(negedge clk);
        host_valid   = 1'b1;
        host_rx      = b;
        resume_pulse = res;
        @(negedge clk);
        host_valid   = 1'b0;
        resume_pulse = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        resume_pulse = 1'b1;
        @(negedge clk);
        resume_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx", 32'(host_tx), 32'h00);
        check("R1 halt", 32'(halt_req), 32'h0);
        check("R1 regs", 32'(ctrl_byte | addr_word | data_word), 32'h0);
        check("R1 bp", 32'(|bp_words), 32'h0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][20:13]);
            check($sformatf("R%0d vec%0d tx", VEC[i][3:0], i), 32'(host_tx), 32'(VEC[i][12:5]));
            check($sformatf("R%0d vec%0d halt", VEC[i][3:0], i), 32'(halt_req), 32'(VEC[i][4]));
        end
        check("R4 ctrl port", 32'(ctrl_byte), 32'h3C);
        check("R4 addr port", 32'(addr_word), 32'h1234);
        check("R4 bp5 port", 32'(bp_words[5*16 +: 16]), 32'hBEEF);
        check("R7 bp0 untouched", 32'(bp_words[15:0]), 32'h0);

        // R5 commit only after the final byte
        xfer(8'h14);
        xfer(8'hCD);
        check("R5 data mid", 32'(data_word), 32'h0);
        xfer(8'hAB);
        check("R5 data done", 32'(data_word), 32'hABCD);
        xfer(8'h04);
        check("R3 data lo", 32'(host_tx), 32'hCD);

        xfer(8'h00);
        xfer(8'h00);
        // R7 high opcode ignored
        xfer(8'hFF);
        check("R7 ff tx", 32'(host_tx), 32'h00);
        xfer(8'h15);
        xfer(8'h11);
        xfer(8'h22);
        check("R7 resync bp0", 32'(bp_words[15:0]), 32'h2211);

        // R6 resume, then tie
        pulse_resume();
        check("R6 resume", 32'(halt_req), 32'h0);
        xfer(8'h1F, 1'b1);
        check("R6 tie", 32'(halt_req), 32'h1);
        pulse_resume();
        check("R6 clear", 32'(halt_req), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule